// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps an SDRAM's contents alive by scheduling auto-refresh. A timer fires at the average interval needed to refresh every row within the retention window. Each firing adds one refresh to a small owed count. While refreshes are owed, the block raises a request towards the command sequencer. Once the sequencer grants it the bus, the block drives a fixed sequence: close all banks, wait the precharge time, refresh, then wait the refresh cycle time before it hands the bus back. Refreshes can therefore be put off while long bursts run, up to the depth of the owed count. When the count is full, an urgent flag tells the sequencer to serve the refresh before it starts any new access.

A low-power input turns the same sequence into self-refresh. The block closes all banks, then issues the refresh command with the clock enable driven low, and keeps the clock enable low for as long as the input stays high. When the input drops, the block raises the clock enable and holds the command bus at no-operation until the recovery time has passed. The owed count is cleared on entry, and the interval timer is held while the device refreshes itself.

The command output packs the three strobes as {RAS_n, CAS_n, WE_n}. The sequencer holds chip select low whenever it forwards these strobes.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is applied, and in the cycle after it is released, the command is NOP (3'b111), a10_o is 0, cke_o is 1, and req_o and urgent_o are 0.
- R2: The interval timer counts INTERVAL = floor(CLK_MHZ*1000*RETENTION_MS/ROW_COUNT) clock edges and adds one owed refresh on the last of them. req_o is high whenever at least one refresh is owed, sleep_req_i is high, or a sequence is in progress.
- R3: The owed count saturates at OWED_MAX. urgent_o is high exactly when the count equals OWED_MAX, and urgent_o implies req_o.
- R4: grant_i is acted on only in the idle state while req_o is high. In the cycle after such a grant, the block drives precharge-all: command 3'b010 with a10_o high. A grant seen in any other state has no effect.
- R5: The refresh command (3'b001, a10_o low, cke_o high) appears exactly TRP_CYC cycles after precharge-all, with NOPs in between. TRP_CYC = max(2, ceil(TRP_NS*CLK_MHZ/1000)).
- R6: After a refresh, the command stays NOP for TRC_CYC-1 cycles. The block is idle again TRC_CYC cycles after the refresh, and a grant can take effect from that cycle. TRC_CYC = max(2, ceil(TRC_NS*CLK_MHZ/1000)).
- R7: Each refresh issued removes one owed refresh. When a timer firing lands in the same cycle, the count is unchanged.
- R8: If sleep_req_i is high when the precharge wait ends, the block issues 3'b001 with cke_o low instead of an auto-refresh. cke_o then stays low with NOP while sleep_req_i stays high. The owed count is cleared and the timer is held at zero.
- R9: After sleep_req_i falls, cke_o rises with NOP for one cycle. TRC_CYC further NOP cycles follow before the block is idle. The interval timer restarts at the cycle in which cke_o rises.
- R10: Whenever req_o is low, the command is NOP and cke_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Sequencer hands the command bus to the scheduler |
| sleep_req_i | input | 1 | Low-power request: enter self-refresh and stay in it while high |
| req_o | output | 1 | Scheduler wants, or holds, the command bus |
| urgent_o | output | 1 | Owed count is full; serve before new accesses |
| cmd_o | output | 3 | Command strobes {RAS_n, CAS_n, WE_n} |
| a10_o | output | 1 | Level for address bit 10 (high selects all banks) |
| cke_o | output | 1 | Clock enable towards the memory |

## Verification
The hardest case to reach is a refresh that retires an owed entry in the same cycle that the timer adds one while the count is full. The count must then stay full, and the only sign of this at the ports is that urgent_o does not drop. The bench gets there by arithmetic. It lets the count saturate, times a grant so that the refresh state falls exactly on an interval boundary, and checks urgent_o on either side of that edge. The restart of the timer after self-refresh is pinned down in a similar way: the first new request must appear exactly one interval after cke_o rises.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_WAIT_RP, ST_REF, ST_WAIT_RC, ST_SR_ENTER, ST_SR_HOLD, ST_SR_EXIT
  } ref_state_e;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_REF = 3'b001;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL = 781
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic tick_o
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = !hold_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (hold_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/owed_refresh_counter.sv
module owed_refresh_counter #(
  parameter int OWED_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic pending_o,
  output logic full_o
);
  localparam int OW = $clog2(OWED_MAX + 1);
  localparam logic [OW-1:0] TOP = OW'(OWED_MAX);

  logic [OW-1:0] owed_q;

  assign pending_o = (owed_q != '0);
  assign full_o    = (owed_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else if (clear_i) owed_q <= '0;
    else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (!full_o)   owed_q <= owed_q + 1'b1;
        2'b01:   if (pending_o) owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end
endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
  import sdram_ref_pkg::*;
#(
  parameter int TRP_CYC = 3,
  parameter int TRC_CYC = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pending_i,
  input  logic       sleep_i,
  input  logic       grant_i,
  output logic       req_o,
  output logic       issue_ref_o,
  output logic       in_sr_o,
  output logic [2:0] cmd_o,
  output logic       a10_o,
  output logic       cke_o
);
  localparam int WMAX = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC;
  localparam int WW   = $clog2(WMAX + 1);

  ref_state_e    state_q, state_d;
  logic [WW-1:0] wcnt_q, wcnt_d;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    unique case (state_q)
      ST_IDLE:     if ((pending_i || sleep_i) && grant_i) state_d = ST_PRE;
      ST_PRE:      begin wcnt_d = WW'(TRP_CYC - 1); state_d = ST_WAIT_RP; end
      ST_WAIT_RP:  if (wcnt_q == WW'(1)) state_d = sleep_i ? ST_SR_ENTER : ST_REF;
                   else wcnt_d = wcnt_q - 1'b1;
      ST_REF:      begin wcnt_d = WW'(TRC_CYC - 1); state_d = ST_WAIT_RC; end
      ST_WAIT_RC:  if (wcnt_q == WW'(1)) state_d = ST_IDLE;
                   else wcnt_d = wcnt_q - 1'b1;
      ST_SR_ENTER: state_d = ST_SR_HOLD;
      ST_SR_HOLD:  if (!sleep_i) state_d = ST_SR_EXIT;
      ST_SR_EXIT:  begin wcnt_d = WW'(TRC_CYC); state_d = ST_WAIT_RC; end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign req_o       = (state_q != ST_IDLE) || pending_i || sleep_i;
  assign issue_ref_o = (state_q == ST_REF);
  assign in_sr_o     = (state_q == ST_SR_ENTER) || (state_q == ST_SR_HOLD);
  assign a10_o       = (state_q == ST_PRE);
  assign cke_o       = !in_sr_o;

  always_comb begin
    unique case (state_q)
      ST_PRE:              cmd_o = CMD_PRE;
      ST_REF, ST_SR_ENTER: cmd_o = CMD_REF;
      default:             cmd_o = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CLK_MHZ      = 100,
  parameter int RETENTION_MS = 64,
  parameter int ROW_COUNT    = 8192,
  parameter int TRP_NS       = 20,
  parameter int TRC_NS       = 70,
  parameter int OWED_MAX     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       grant_i,
  input  logic       sleep_req_i,
  output logic       req_o,
  output logic       urgent_o,
  output logic [2:0] cmd_o,
  output logic       a10_o,
  output logic       cke_o
);
  localparam int INTERVAL = (CLK_MHZ * 1000 * RETENTION_MS) / ROW_COUNT;
  localparam int TRP_RAW  = (TRP_NS * CLK_MHZ + 999) / 1000;
  localparam int TRC_RAW  = (TRC_NS * CLK_MHZ + 999) / 1000;
  localparam int TRP_CYC  = (TRP_RAW > 2) ? TRP_RAW : 2;
  localparam int TRC_CYC  = (TRC_RAW > 2) ? TRC_RAW : 2;

  logic tick, pending, full, issue_ref, in_sr;

  refresh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (in_sr),
    .tick_o (tick)
  );

  owed_refresh_counter #(.OWED_MAX(OWED_MAX)) u_owed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (in_sr),
    .inc_i     (tick),
    .dec_i     (issue_ref),
    .pending_o (pending),
    .full_o    (full)
  );

  refresh_fsm #(.TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pending_i   (pending),
    .sleep_i     (sleep_req_i),
    .grant_i     (grant_i),
    .req_o       (req_o),
    .issue_ref_o (issue_ref),
    .in_sr_o     (in_sr),
    .cmd_o       (cmd_o),
    .a10_o       (a10_o),
    .cke_o       (cke_o)
  );

  assign urgent_o = full;
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_o,
  input logic       urgent_o,
  input logic [2:0] cmd_o,
  input logic       a10_o,
  input logic       cke_o
);
  // R4
  pre_all_banks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'b010) |-> a10_o);
  // R5
  pre_then_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'b010) |=> (cmd_o == 3'b111));
  // R6
  ref_then_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'b001 && cke_o) |=> (cmd_o == 3'b111 && cke_o));
  // R3
  urgent_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> req_o);
  // R8
  cke_fall_on_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (cmd_o == 3'b001));
  // R9
  cke_rise_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (cmd_o == 3'b111) ##1 (cmd_o == 3'b111));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (cmd_o == 3'b111 && cke_o && !a10_o));
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_o    (req_o),
  .urgent_o (urgent_o),
  .cmd_o    (cmd_o),
  .a10_o    (a10_o),
  .cke_o    (cke_o)
);

// File: tb/sdram_refresh_sched_tb.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb;
  localparam int CLK_MHZ = 2, RET_MS = 64, ROWS = 8192;
  localparam int TRP_NS = 1000, TRC_NS = 2500, OMAX = 4;
  localparam int I   = (CLK_MHZ * 1000 * RET_MS) / ROWS;                 // 15
  localparam int TRP = ((TRP_NS * CLK_MHZ + 999) / 1000 > 2) ? (TRP_NS * CLK_MHZ + 999) / 1000 : 2;
  localparam int TRC = ((TRC_NS * CLK_MHZ + 999) / 1000 > 2) ? (TRC_NS * CLK_MHZ + 999) / 1000 : 2;
  localparam logic [2:0] NOP = 3'b111, PRE = 3'b010, REF = 3'b001;

  logic clk = 1'b0, rst_n = 1'b0, grant = 1'b0, sleep = 1'b0;
  logic req, urgent, a10, cke;
  logic [2:0] cmd;
  int checks = 0, errors = 0, k = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_refresh_sched #(
    .CLK_MHZ(CLK_MHZ), .RETENTION_MS(RET_MS), .ROW_COUNT(ROWS),
    .TRP_NS(TRP_NS), .TRC_NS(TRC_NS), .OWED_MAX(OMAX)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .grant_i(grant), .sleep_req_i(sleep),
    .req_o(req), .urgent_o(urgent), .cmd_o(cmd), .a10_o(a10), .cke_o(cke)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: got %0d expected %0d", tag, what, k, act, exp);
    end
  endtask

  task automatic chk_bus(string tag, logic [2:0] ec, logic ea, logic ek);
    chk(tag, "cmd", int'(cmd), int'(ec));
    chk(tag, "a10", int'(a10), int'(ea));
    chk(tag, "cke", int'(cke), int'(ek));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    k++;
  endtask

  task automatic step_to(int target);
    while (k < target) step();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (3) @(negedge clk);
    chk_bus("R1", NOP, 1'b0, 1'b1);
    chk("R1", "req", int'(req), 0);
    chk("R1", "urgent", int'(urgent), 0);
    rst_n = 1'b1;
    chk_bus("R1", NOP, 1'b0, 1'b1);

    // timer and saturation sweep, no grant
    for (int n = 1; n <= I * OMAX + 5; n++) begin
      step();
      chk("R2", "req", int'(req), int'(n >= I));
      chk("R3", "urgent", int'(urgent), int'(n >= I * OMAX));
      chk_bus("R10", NOP, 1'b0, 1'b1);
    end

    // first refresh sequence, count full
    grant = 1'b1;
    step(); chk_bus("R4", PRE, 1'b1, 1'b1);
    grant = 1'b0;
    for (int j = 1; j < TRP; j++) begin step(); chk_bus("R5", NOP, 1'b0, 1'b1); end
    step(); chk_bus("R5", REF, 1'b0, 1'b1);
    chk("R7", "urgent before retire", int'(urgent), 1);
    step(); chk("R7", "urgent after retire", int'(urgent), 0);
    step_to(72);
    chk("R6", "req busy", int'(req), 1);
    grant = 1'b1;                           // seen while still recovering
    step(); chk_bus("R6", NOP, 1'b0, 1'b1); // k=73 idle, grant not yet acted on
    step(); chk_bus("R4", PRE, 1'b1, 1'b1); // k=74
    grant = 1'b0;
    step(); chk("R2", "tick to full", int'(urgent), 1);  // k=75
    step(); chk_bus("R5", REF, 1'b0, 1'b1);              // k=76
    step(); chk("R7", "retire", int'(urgent), 0);        // k=77
    step_to(89); chk("R7", "count three", int'(urgent), 0);
    step(); chk("R3", "full again", int'(urgent), 1);    // k=90

    // refresh state coincides with tick at edge 105
    step_to(101);
    grant = 1'b1;
    step(); chk_bus("R4", PRE, 1'b1, 1'b1);              // k=102
    grant = 1'b0;
    step_to(104); chk_bus("R5", REF, 1'b0, 1'b1);
    step(); chk("R7", "tick and retire net", int'(urgent), 1);  // k=105

    // self-refresh
    step_to(110);
    sleep = 1'b1;
    grant = 1'b1;
    step(); chk_bus("R8", PRE, 1'b1, 1'b1);              // k=111
    grant = 1'b0;
    step(); chk_bus("R8", NOP, 1'b0, 1'b1);              // k=112
    step(); chk_bus("R8", REF, 1'b0, 1'b0);              // k=113
    for (int j = 0; j < 21; j++) begin
      step();
      chk_bus("R8", NOP, 1'b0, 1'b0);
      chk("R8", "urgent cleared", int'(urgent), 0);
      chk("R8", "req held", int'(req), 1);
    end
    sleep = 1'b0;                                        // k=134
    step(); e = k;                                       // k=135
    chk_bus("R9", NOP, 1'b0, 1'b1);
    for (int j = 1; j <= TRC; j++) begin
      step();
      chk_bus("R9", NOP, 1'b0, 1'b1);
      chk("R9", "req in recovery", int'(req), 1);
    end
    for (int j = TRC + 1; j < I; j++) begin
      step();
      chk("R9", "req idle after exit", int'(req), 0);
      chk_bus("R10", NOP, 1'b0, 1'b1);
    end
    step();
    chk("R9", "first tick after exit", k - e, I);
    chk("R9", "req after interval", int'(req), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule